// File: doc/BRIEF.md
# Power Domain Off/On Sequencer

This controller takes a switchable clock/power domain out of service and brings it back, when that domain is reached through register clock-crossing bridges. An off command starts the shutdown. The controller closes the far side of the bridge to new traffic. It waits until the single transfer the bridge can hold has finished. It then puts the domain into reset and, after that, cuts its power.

An on command runs the same steps in reverse. Power comes back first. Once the supply reports good, reset is held for a minimum number of cycles set by the `hold_cycles` input. Reset is then released, and traffic is let through last. Every wait is open-ended and has no timeout.

All control outputs come straight from flops, so each one changes only on a clock edge. The two resting states accept exactly one command each. A command that arrives at any other time is dropped.

Top module: `pwr_domain_seq`

## Requirements
- R1: After system reset the block rests in the off state: `dom_reset`=1, `pwr_en`=0, `allow`=0, `busy`=0, `done`=0.
- R2: In the on state, `cmd_off` sampled high at a clock edge makes `allow` and `busy` change in that same edge: `allow` goes low and `busy` goes high. `pwr_en` stays 1 and `dom_reset` stays 0.
- R3: Once `allow` is low, `dom_reset` stays 0 for as long as `inflight` is sampled high. The wait starts one cycle after gating. `dom_reset` goes high on the first edge that samples `inflight` low.
- R4: `pwr_en` falls exactly one cycle after `dom_reset` rises, and only while `dom_reset` is held high.
- R5: In the off state, `cmd_on` sampled high makes `pwr_en` and `busy` go high in that same edge. `dom_reset` stays high for as long as `power_good` is sampled low.
- R6: After the edge that samples `power_good` high, `dom_reset` stays high for exactly `hold_cycles` more cycles. When `hold_cycles` is 0, it stays high for 1 more cycle.
- R7: `allow` rises exactly one cycle after `dom_reset` falls, with `pwr_en` high.
- R8: Commands are dropped everywhere except in the two resting states. While the sequence runs, neither `cmd_on` nor `cmd_off` changes its course. `cmd_on` has no effect in the on state, and `cmd_off` has no effect in the off state.
- R9: `busy` is high from the first step to the last. `done` pulses for exactly one cycle on the edge where the block reaches a resting state, and `busy` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| cmd_off | input | 1 | Request to shut the domain down |
| cmd_on | input | 1 | Request to bring the domain up |
| inflight | input | 1 | Bridge reports an outstanding transfer |
| power_good | input | 1 | Domain supply is stable |
| hold_cycles | input | CNT_W | Minimum reset hold after power is good |
| allow | output | 1 | Lets traffic through the far side of the bridge |
| dom_reset | output | 1 | Reset into the target domain, active high |
| pwr_en | output | 1 | Power enable for the target domain |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The assertions assume that `inflight` only drops after traffic has been gated, and that `power_good` is not sampled high before power is enabled. The ordering checks compare a present edge with the cycle before it, so they rely on every input being synchronous to `clk`. The stimulus changes inputs only just after a rising edge and holds `inflight` high into the drain wait. It raises `power_good` only once `pwr_en` is high. Pulses on `cmd_on` and `cmd_off` are also placed in the middle of each wait, and in the resting state where they must be dropped.

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_off,
  input  logic             cmd_on,
  input  logic             inflight,
  input  logic             power_good,
  input  logic [CNT_W-1:0] hold_cycles,
  output logic             allow,
  output logic             dom_reset,
  output logic             pwr_en,
  output logic             busy,
  output logic             done
);

  typedef enum logic [2:0] {
    S_ON, S_GATE, S_DRAIN, S_RESET, S_OFF, S_POWERUP, S_RELEASE, S_OPEN
  } state_t;

  state_t state, nxt;
  logic [CNT_W-1:0] cnt;
  logic hold_met;

  assign hold_met = (hold_cycles == '0) || (cnt == hold_cycles - 1'b1);

  always_comb begin
    nxt = state;
    case (state)
      S_ON:      if (cmd_off)    nxt = S_GATE;
      S_GATE:                    nxt = S_DRAIN;
      S_DRAIN:   if (!inflight)  nxt = S_RESET;
      S_RESET:                   nxt = S_OFF;
      S_OFF:     if (cmd_on)     nxt = S_POWERUP;
      S_POWERUP: if (power_good) nxt = S_RELEASE;
      S_RELEASE: if (hold_met)   nxt = S_OPEN;
      S_OPEN:                    nxt = S_ON;
      default:                   nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_OFF;
      cnt       <= '0;
      allow     <= 1'b0;
      dom_reset <= 1'b1;
      pwr_en    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= nxt;
      cnt       <= (state == S_RELEASE) ? cnt + 1'b1 : '0;
      allow     <= (nxt == S_ON);
      dom_reset <= (nxt == S_RESET) || (nxt == S_OFF) ||
                   (nxt == S_POWERUP) || (nxt == S_RELEASE);
      pwr_en    <= (nxt != S_OFF);
      busy      <= (nxt != S_ON) && (nxt != S_OFF);
      done      <= (state != nxt) && ((nxt == S_ON) || (nxt == S_OFF));
    end
  end

  assert_gate_on_command_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(allow) |-> $past(cmd_off) && busy && pwr_en && !dom_reset);

  assert_reset_after_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_reset) |-> !allow && !$past(inflight) && pwr_en);

  assert_power_off_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> dom_reset && $past(dom_reset));

  assert_release_with_power_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_reset) |-> pwr_en && $past(pwr_en) && !allow);

  assert_allow_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(allow) |-> pwr_en && !dom_reset && $past(!dom_reset));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/pwr_domain_seq_bench.sv
module pwr_domain_seq_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, cmd_off, cmd_on, inflight, power_good;
  logic [CNT_W-1:0] hold_cycles;
  logic allow, dom_reset, pwr_en, busy, done;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwr_domain_seq #(.CNT_W(CNT_W)) u_pwr_domain_seq (
    .clk(clk), .rst_n(rst_n), .cmd_off(cmd_off), .cmd_on(cmd_on),
    .inflight(inflight), .power_good(power_good), .hold_cycles(hold_cycles),
    .allow(allow), .dom_reset(dom_reset), .pwr_en(pwr_en), .busy(busy), .done(done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 0; cmd_off = 0; cmd_on = 0; inflight = 0; power_good = 0; hold_cycles = 3;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1", "dom_reset", dom_reset, 1);
    chk("R1", "pwr_en", pwr_en, 0);
    chk("R1", "allow", allow, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
  endtask

  task automatic test_startup(int hold, int pg_delay);
    int n;
    hold_cycles = hold[CNT_W-1:0];
    power_good = 0;
    cmd_on = 1;
    tick();
    cmd_on = 0;
    chk("R5", "pwr_en up", pwr_en, 1);
    chk("R5", "busy up", busy, 1);
    chk("R5", "reset held", dom_reset, 1);
    chk("R5", "allow low", allow, 0);
    for (int i = 0; i < pg_delay; i++) begin
      tick();
      chk("R5", "reset while power not good", dom_reset, 1);
    end
    power_good = 1;
    tick();
    n = 0;
    while (dom_reset && n < 300) begin
      tick();
      n++;
    end
    chk("R6", "reset hold cycles", n, (hold == 0) ? 1 : hold);
    chk("R7", "allow still low at release", allow, 0);
    chk("R7", "pwr_en at release", pwr_en, 1);
    chk("R9", "busy at release", busy, 1);
    tick();
    chk("R7", "allow raised", allow, 1);
    chk("R9", "done pulse on", done, 1);
    chk("R9", "busy cleared on", busy, 0);
    tick();
    chk("R9", "done single", done, 0);
    power_good = 0;
  endtask

  task automatic test_shutdown(int drain);
    cmd_off = 1; inflight = 1;
    tick();
    cmd_off = 0;
    chk("R2", "allow dropped", allow, 0);
    chk("R2", "busy raised", busy, 1);
    chk("R2", "pwr_en kept", pwr_en, 1);
    chk("R2", "reset kept low", dom_reset, 0);
    tick();
    chk("R3", "no reset after gate", dom_reset, 0);
    for (int i = 0; i < drain; i++) begin
      tick();
      chk("R3", "no reset while inflight", dom_reset, 0);
    end
    inflight = 0;
    tick();
    chk("R3", "reset after drain", dom_reset, 1);
    chk("R4", "power kept during reset", pwr_en, 1);
    tick();
    chk("R4", "power removed", pwr_en, 0);
    chk("R4", "reset held while off", dom_reset, 1);
    chk("R9", "done pulse off", done, 1);
    chk("R9", "busy cleared off", busy, 0);
    tick();
    chk("R9", "done single off", done, 0);
  endtask

  task automatic test_ignore();
    cmd_off = 1;
    tick(); tick();
    cmd_off = 0;
    chk("R8", "off ignored in off: pwr_en", pwr_en, 0);
    chk("R8", "off ignored in off: busy", busy, 0);
    hold_cycles = 2;
    cmd_on = 1;
    tick();
    cmd_on = 0;
    cmd_off = 1;
    tick(); tick();
    cmd_off = 0;
    chk("R8", "off ignored in powerup: pwr_en", pwr_en, 1);
    chk("R8", "off ignored in powerup: reset", dom_reset, 1);
    chk("R8", "off ignored in powerup: allow", allow, 0);
    power_good = 1;
    repeat (4) tick();
    chk("R8", "startup completes: allow", allow, 1);
    chk("R8", "startup completes: busy", busy, 0);
    power_good = 0;
    cmd_on = 1;
    tick(); tick();
    cmd_on = 0;
    chk("R8", "on ignored in on: allow", allow, 1);
    chk("R8", "on ignored in on: busy", busy, 0);
    cmd_off = 1; inflight = 1;
    tick();
    cmd_off = 0;
    tick();
    cmd_on = 1; cmd_off = 1;
    tick(); tick();
    cmd_on = 0; cmd_off = 0;
    chk("R8", "cmds ignored in drain: reset", dom_reset, 0);
    chk("R8", "cmds ignored in drain: allow", allow, 0);
    chk("R8", "cmds ignored in drain: busy", busy, 1);
    inflight = 0;
    tick(); tick();
    chk("R8", "shutdown completes: pwr_en", pwr_en, 0);
    chk("R8", "shutdown completes: busy", busy, 0);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_startup(3, 2);
        test_shutdown(4);
        test_startup(0, 0);
        test_shutdown(0);
        test_startup(1, 5);
        test_shutdown(1);
        test_ignore();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule